// File: doc/BRIEF.md
# Segment Descriptor Protection Check Unit

This unit sits between a descriptor cache and the address generation path of a processor that uses segmented memory protection. For each request it receives an already-fetched 64-bit segment descriptor, the selector that named it, the current privilege level and an operation. The operation is either loading a segment register (data or stack) or accessing memory (read, write or execute) at a 32-bit offset. The unit splits the descriptor into its base, limit, granularity, presence, privilege and type fields. It then judges whether the request is legal and returns either a linear address or a single prioritised fault code.

The judgement is purely combinational and is followed by one registered response stage. Requests and responses both use valid/ready handshakes. A request transfers on a clock edge where `req_valid` and `req_ready` are both high. Its response appears on `rsp_valid` one cycle later. The response stays unchanged for as long as `rsp_ready` is low. `req_ready` is high whenever the response register is empty or is being drained in the same cycle. This allows one transfer per cycle when the consumer never stalls.

The descriptor layout uses the following positions:
- limit bits 15:0 in descriptor bits 15:0
- base bits 15:0 in descriptor bits 31:16
- base bits 23:16 in descriptor bits 39:32
- access byte in descriptor bits 47:40, with present at bit 47, privilege at bits 46:45, code/data-versus-system at bit 44 and type at bits 43:40
- limit bits 19:16 in descriptor bits 51:48
- granularity at bit 55
- base bits 31:24 in descriptor bits 63:56

Within the type nibble:
- type bit 3 set marks code.
- For code, bit 2 marks conforming and bit 1 marks readable.
- For data, bit 1 marks writable.

Top module: `seg_check_unit`

## Requirements
- R1: A legal memory access returns linear = base + offset (modulo 2^32), where the 32-bit base is taken from descriptor bits 63:56, 39:32 and 31:16 (high to low). A legal segment load returns linear = base.
- R2: With granularity (bit 55) clear, the effective limit is the 20-bit limit in bytes. With it set, the effective limit is the 20-bit limit shifted left by 12 with the low 12 bits all ones.
- R3: A read, write or execute whose offset is greater than the effective limit faults with code 4 (limit). An offset equal to the limit is legal. Segment loads never take a limit fault.
- R4: When the present bit (47) is clear, every request faults with code 1 (absent), whatever its other fields hold.
- R5: Operation codes are 0 data load, 1 stack load, 2 read, 3 write and 4 execute. The following cases fault with code 2 (type): write to code, write to non-writable data, read of non-readable code, execute of data, and any operation code from 5 to 7.
- R6: A descriptor with bit 44 clear (system kind, for example type 0010, a local descriptor table) faults with code 2 for every operation.
- R7: A data load of data or readable code needs DPL >= max(CPL, RPL), where RPL is selector bits 1:0. Otherwise it faults with code 3 (privilege). Conforming code skips this privilege test. Non-readable code faults with code 2.
- R8: A stack load needs writable data (otherwise code 2) and needs RPL = CPL and DPL = CPL (otherwise code 3).
- R9: When several faults apply, the reported code is the first of absent, type, privilege, limit. Code 0 means no fault.
- R10: A request accepted on an edge produces `rsp_valid` after that edge. The response is held unchanged while `rsp_ready` is low. `req_ready` is low exactly while a held response is not being taken.
- R11: A response that carries a fault has `rsp_linear` equal to zero.
- R12: After reset, `rsp_valid` is low and `req_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Unit can take a request this cycle |
| req_desc | input | 64 | Segment descriptor |
| req_selector | input | 16 | Selector; bits 1:0 are the requested privilege |
| req_cpl | input | 2 | Current privilege level |
| req_op | input | 3 | Operation code (see R5) |
| req_offset | input | 32 | Offset for memory accesses |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Consumer takes the response |
| rsp_fault | output | 3 | Fault code, 0 when legal |
| rsp_linear | output | 32 | Linear address, zero on fault |

## Verification
The assertions check several properties on every cycle:
- The absent fault always wins.
- A limit fault only ever follows a memory access.
- An accepted stack load satisfies the privilege equalities.
- A system descriptor never passes the rights test.
- The response register holds steady under back-pressure, and a faulting response carries a zero address.

Only the bench's scenarios can show the exact linear sums, the effect of granularity on the limit edge, the precise privilege comparisons, and the ordering of a request that queues behind a stalled response. These are checked against a bench model over directed corners and seeded random descriptors.

// File: rtl/segchk_pkg.sv
package segchk_pkg;
  localparam int DESC_W     = 64;
  localparam int BASE_W     = 32;
  localparam int LIM_W      = 20;
  localparam int GRAN_SHIFT = 12;
  localparam int PL_W       = 2;
  localparam int OP_W       = 3;
  localparam int FLT_W      = 3;

  typedef enum logic [OP_W-1:0] {
    OP_LOAD_DATA  = 3'd0,
    OP_LOAD_STACK = 3'd1,
    OP_READ       = 3'd2,
    OP_WRITE      = 3'd3,
    OP_EXEC       = 3'd4
  } seg_op_e;

  typedef enum logic [FLT_W-1:0] {
    FLT_NONE   = 3'd0,
    FLT_ABSENT = 3'd1,
    FLT_TYPE   = 3'd2,
    FLT_PRIV   = 3'd3,
    FLT_LIMIT  = 3'd4
  } fault_e;
endpackage

// File: rtl/seg_desc_decode.sv
module seg_desc_decode
  import segchk_pkg::*;
(
  input  logic [DESC_W-1:0] desc,
  output logic [BASE_W-1:0] base,
  output logic [BASE_W-1:0] eff_limit,
  output logic              present,
  output logic [PL_W-1:0]   dpl,
  output logic              is_sys,
  output logic              is_code,
  output logic              conforming,
  output logic              rw_bit
);
  localparam int LIM_LO_W  = 16;
  localparam int LIM_HI_W  = LIM_W - LIM_LO_W;
  localparam int SCALED_W  = LIM_W + GRAN_SHIFT;
  localparam int ACC_LSB   = 40;
  localparam int LIM_HI_LSB = 48;
  localparam int GRAN_BIT  = 55;

  logic [7:0]        acc;
  logic [LIM_W-1:0]  lim_raw;
  logic              gran;
  logic [BASE_W-1:0] byte_lim;
  logic [BASE_W-1:0] page_lim;
  logic [SCALED_W-1:0] scaled;
  logic              unused_desc;

  assign acc     = desc[ACC_LSB +: 8];
  assign lim_raw = {desc[LIM_HI_LSB +: LIM_HI_W], desc[LIM_LO_W-1:0]};
  assign gran    = desc[GRAN_BIT];
  assign base    = {desc[63:56], desc[39:32], desc[31:16]};

  assign present    = acc[7];
  assign dpl        = acc[6:5];
  assign is_sys     = ~acc[4];
  assign is_code    = acc[3];
  assign conforming = acc[2];
  assign rw_bit     = acc[1];

  assign unused_desc = ^{desc[54:52], acc[0]};

  assign scaled   = {lim_raw, {GRAN_SHIFT{1'b1}}};
  assign byte_lim = {{(BASE_W-LIM_W){1'b0}}, lim_raw};

  generate
    if (SCALED_W >= BASE_W) begin : g_trunc
      assign page_lim = scaled[BASE_W-1:0];
    end else begin : g_pad
      assign page_lim = {{(BASE_W-SCALED_W){1'b0}}, scaled};
    end
  endgenerate

  assign eff_limit = gran ? page_lim : byte_lim;

  always_comb begin
    if (!gran) p_byte_lim_r2: assert (eff_limit <= {{(BASE_W-LIM_W){1'b0}}, {LIM_W{1'b1}}});
    if (gran)  p_page_fill_r2: assert (&eff_limit[GRAN_SHIFT-1:0]);
  end
endmodule

// File: rtl/seg_rights_check.sv
module seg_rights_check
  import segchk_pkg::*;
(
  input  logic [OP_W-1:0] op,
  input  logic [PL_W-1:0] cpl,
  input  logic [PL_W-1:0] rpl,
  input  logic [PL_W-1:0] dpl,
  input  logic            is_sys,
  input  logic            is_code,
  input  logic            conforming,
  input  logic            rw_bit,
  output logic            type_bad,
  output logic            priv_bad,
  output logic            is_access
);
  logic [PL_W-1:0] eff_pl;

  assign eff_pl = (cpl > rpl) ? cpl : rpl;

  always_comb begin
    type_bad  = 1'b0;
    priv_bad  = 1'b0;
    is_access = 1'b0;
    case (op)
      OP_LOAD_DATA: begin
        type_bad = is_sys | (is_code & ~rw_bit);
        priv_bad = ~(is_code & conforming) & (dpl < eff_pl);
      end
      OP_LOAD_STACK: begin
        type_bad = is_sys | is_code | ~rw_bit;
        priv_bad = (rpl != cpl) | (dpl != cpl);
      end
      OP_READ: begin
        type_bad  = is_sys | (is_code & ~rw_bit);
        is_access = 1'b1;
      end
      OP_WRITE: begin
        type_bad  = is_sys | is_code | ~rw_bit;
        is_access = 1'b1;
      end
      OP_EXEC: begin
        type_bad  = is_sys | ~is_code;
        is_access = 1'b1;
      end
      default: type_bad = 1'b1;
    endcase
  end

  always_comb begin
    if (is_sys) p_sys_rejected_r6: assert (type_bad);
    if (is_access) p_access_no_priv_r7: assert (!priv_bad);
  end
endmodule

// File: rtl/seg_limit_addr.sv
module seg_limit_addr
  import segchk_pkg::*;
(
  input  logic [BASE_W-1:0] base,
  input  logic [BASE_W-1:0] eff_limit,
  input  logic [BASE_W-1:0] offset,
  input  logic              check_en,
  output logic              over_limit,
  output logic [BASE_W-1:0] sum
);
  assign over_limit = check_en & (offset > eff_limit);
  assign sum        = base + offset;

  always_comb begin
    if (!check_en) p_no_limit_on_load_r3: assert (!over_limit);
  end
endmodule

// File: rtl/seg_rsp_stage.sv
module seg_rsp_stage #(
  parameter int W = 35
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_data,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_data
);
  logic         v_q;
  logic [W-1:0] d_q;

  assign in_ready  = ~v_q | out_ready;
  assign out_valid = v_q;
  assign out_data  = d_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      v_q <= 1'b0;
      d_q <= '0;
    end else if (in_ready) begin
      v_q <= in_valid;
      if (in_valid) d_q <= in_data;
    end
  end

  p_hold_stalled_r10: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data));

  p_accept_shows_r10: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> out_valid && out_data == $past(in_data));
endmodule

// File: rtl/seg_check_unit.sv
module seg_check_unit
  import segchk_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  output logic                req_ready,
  input  logic [DESC_W-1:0]   req_desc,
  input  logic [15:0]         req_selector,
  input  logic [PL_W-1:0]     req_cpl,
  input  logic [OP_W-1:0]     req_op,
  input  logic [BASE_W-1:0]   req_offset,
  output logic                rsp_valid,
  input  logic                rsp_ready,
  output logic [FLT_W-1:0]    rsp_fault,
  output logic [BASE_W-1:0]   rsp_linear
);
  localparam int RSP_W = FLT_W + BASE_W;

  logic [BASE_W-1:0] base, eff_limit, sum, lin_c;
  logic              present, is_sys, is_code, conforming, rw_bit;
  logic [PL_W-1:0]   dpl, rpl;
  logic              type_bad, priv_bad, is_access, over_limit;
  logic [FLT_W-1:0]  fault_c;
  logic [RSP_W-1:0]  rsp_data;
  logic              unused_sel;

  assign rpl        = req_selector[PL_W-1:0];
  assign unused_sel = ^req_selector[15:PL_W];

  seg_desc_decode u_dec (
    .desc(req_desc), .base(base), .eff_limit(eff_limit), .present(present),
    .dpl(dpl), .is_sys(is_sys), .is_code(is_code), .conforming(conforming),
    .rw_bit(rw_bit)
  );

  seg_rights_check u_rights (
    .op(req_op), .cpl(req_cpl), .rpl(rpl), .dpl(dpl), .is_sys(is_sys),
    .is_code(is_code), .conforming(conforming), .rw_bit(rw_bit),
    .type_bad(type_bad), .priv_bad(priv_bad), .is_access(is_access)
  );

  seg_limit_addr u_lim (
    .base(base), .eff_limit(eff_limit), .offset(req_offset),
    .check_en(is_access), .over_limit(over_limit), .sum(sum)
  );

  always_comb begin
    if (!present)        fault_c = FLT_ABSENT;
    else if (type_bad)   fault_c = FLT_TYPE;
    else if (priv_bad)   fault_c = FLT_PRIV;
    else if (over_limit) fault_c = FLT_LIMIT;
    else                 fault_c = FLT_NONE;
  end

  assign lin_c    = (fault_c != FLT_NONE) ? '0 : (is_access ? sum : base);
  assign rsp_data = {fault_c, lin_c};

  seg_rsp_stage #(.W(RSP_W)) u_out (
    .clk(clk), .rst_n(rst_n), .in_valid(req_valid), .in_ready(req_ready),
    .in_data(rsp_data), .out_valid(rsp_valid), .out_ready(rsp_ready),
    .out_data({rsp_fault, rsp_linear})
  );

  p_absent_first_r4: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !present |-> fault_c == FLT_ABSENT);

  p_limit_access_only_r3: assert property (@(posedge clk) disable iff (!rst_n)
    fault_c == FLT_LIMIT |-> is_access);

  p_stack_equal_r8: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_op == OP_LOAD_STACK && fault_c == FLT_NONE
      |-> rpl == req_cpl && dpl == req_cpl && !is_code);

  p_fault_zero_lin_r11: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_fault != FLT_NONE |-> rsp_linear == '0);

  p_exec_needs_code_r5: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && present && req_op == OP_EXEC && !is_code |-> fault_c == FLT_TYPE);
endmodule

// File: tb/seg_check_unit_test.sv
module seg_check_unit_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid, req_ready, rsp_valid, rsp_ready;
  logic [63:0] req_desc;
  logic [15:0] req_selector;
  logic [1:0]  req_cpl;
  logic [2:0]  req_op;
  logic [31:0] req_offset;
  logic [2:0]  rsp_fault;
  logic [31:0] rsp_linear;
  int          errors = 0;
  int          checks = 0;
  bit          done = 0;

  always #2 clk = ~clk;

  seg_check_unit uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_desc(req_desc), .req_selector(req_selector), .req_cpl(req_cpl),
    .req_op(req_op), .req_offset(req_offset), .rsp_valid(rsp_valid),
    .rsp_ready(rsp_ready), .rsp_fault(rsp_fault), .rsp_linear(rsp_linear)
  );

  function automatic logic [63:0] mk_desc(input logic [31:0] b, input logic [19:0] l,
      input logic g, input logic p, input logic [1:0] dp, input logic s, input logic [3:0] t);
    return {b[31:24], g, 3'b000, l[19:16], p, dp, s, t, b[23:16], b[15:0], l[15:0]};
  endfunction

  function automatic logic [34:0] model(input logic [63:0] d, input logic [1:0] rp,
      input logic [1:0] c, input logic [2:0] op, input logic [31:0] off);
    logic [31:0] b, lim;
    logic p, s, code, cf, rw, acc, tb, pb, lb;
    logic [1:0] dp, mx;
    b    = {d[63:56], d[39:32], d[31:16]};
    lim  = d[55] ? {d[51:48], d[15:0], 12'hFFF} : {12'h000, d[51:48], d[15:0]};
    p = d[47]; dp = d[46:45]; s = d[44]; code = d[43]; cf = d[42]; rw = d[41];
    mx = (rp > c) ? rp : c;
    acc = (op >= 3'd2) && (op <= 3'd4);
    tb = 0; pb = 0;
    case (op)
      3'd0: begin tb = !s || (code && !rw); pb = !(code && cf) && (dp < mx); end
      3'd1: begin tb = !s || code || !rw; pb = (rp != c) || (dp != c); end
      3'd2: tb = !s || (code && !rw);
      3'd3: tb = !s || code || !rw;
      3'd4: tb = !s || !code;
      default: tb = 1;
    endcase
    lb = acc && (off > lim);
    if (!p)      return {3'd1, 32'h0};
    else if (tb) return {3'd2, 32'h0};
    else if (pb) return {3'd3, 32'h0};
    else if (lb) return {3'd4, 32'h0};
    else         return {3'd0, acc ? b + off : b};
  endfunction

  task automatic chk(input string tag, input logic [34:0] act, input logic [34:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got fault=%0d lin=%h, expected fault=%0d lin=%h",
               tag, act[34:32], act[31:0], exp[34:32], exp[31:0]);
    end
  endtask

  task automatic send(input string tag, input logic [63:0] d, input logic [1:0] rp,
      input logic [1:0] c, input logic [2:0] op, input logic [31:0] off);
    logic [34:0] e;
    req_desc = d; req_selector = {14'h1234, rp}; req_cpl = c; req_op = op;
    req_offset = off; req_valid = 1'b1;
    e = model(d, rp, c, op, off);
    @(negedge clk);
    req_valid = 1'b0;
    chk({tag, " valid"}, {34'h0, rsp_valid}, {34'h0, 1'b1});
    chk(tag, {rsp_fault, rsp_linear}, e);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [63:0] da, db, dr;
    logic [34:0] ea, eb;
    void'($urandom(32'h5EED_0042));
    rst_n = 0; req_valid = 0; rsp_ready = 1;
    req_desc = '0; req_selector = '0; req_cpl = '0; req_op = '0; req_offset = '0;
    repeat (3) @(negedge clk);
    chk("R12 reset valid/ready", {33'h0, rsp_valid, req_ready}, {33'h0, 1'b0, 1'b1});
    rst_n = 1;
    @(negedge clk);

    // R1 base assembly and sum
    send("R1 read sum", mk_desc(32'h12345678, 20'hFFFFF, 0, 1, 0, 1, 4'b0010), 0, 0, 3'd2, 32'h10);
    send("R1 load base", mk_desc(32'h00A02000, 20'h0FFFF, 0, 1, 3, 1, 4'b0010), 3, 3, 3'd0, 32'hFFFF_FFFF);
    // R2 / R3 limits
    send("R2 page edge ok", mk_desc(32'h1000, 20'h00001, 1, 1, 0, 1, 4'b0010), 0, 0, 3'd2, 32'h1FFF);
    send("R2 page over", mk_desc(32'h1000, 20'h00001, 1, 1, 0, 1, 4'b0010), 0, 0, 3'd2, 32'h2000);
    send("R2 byte max ok", mk_desc(32'h0, 20'hFFFFF, 0, 1, 0, 1, 4'b0010), 0, 0, 3'd2, 32'hFFFFF);
    send("R2 byte max over", mk_desc(32'h0, 20'hFFFFF, 0, 1, 0, 1, 4'b0010), 0, 0, 3'd2, 32'h100000);
    send("R3 equal ok", mk_desc(32'h400, 20'h10, 0, 1, 0, 1, 4'b1010), 0, 0, 3'd4, 32'h10);
    send("R3 one over", mk_desc(32'h400, 20'h10, 0, 1, 0, 1, 4'b1010), 0, 0, 3'd4, 32'h11);
    send("R3 load no limit", mk_desc(32'h400, 20'h0, 0, 1, 3, 1, 4'b0010), 0, 0, 3'd0, 32'hFFFF);
    // R4 absent wins
    send("R4 absent", mk_desc(32'h400, 20'h0, 0, 0, 0, 0, 4'b0000), 3, 0, 3'd7, 32'hFFFF);
    // R5 type rules
    send("R5 write code", mk_desc(32'h0, 20'hFFFFF, 0, 1, 0, 1, 4'b1010), 0, 0, 3'd3, 32'h4);
    send("R5 write ro data", mk_desc(32'h0, 20'hFFFFF, 0, 1, 0, 1, 4'b0000), 0, 0, 3'd3, 32'h4);
    send("R5 read exec-only", mk_desc(32'h0, 20'hFFFFF, 0, 1, 0, 1, 4'b1000), 0, 0, 3'd2, 32'h4);
    send("R5 exec data", mk_desc(32'h0, 20'hFFFFF, 0, 1, 0, 1, 4'b0010), 0, 0, 3'd4, 32'h4);
    send("R5 bad opcode", mk_desc(32'h0, 20'hFFFFF, 0, 1, 0, 1, 4'b0010), 0, 0, 3'd5, 32'h4);
    send("R5 write data ok", mk_desc(32'h8000, 20'hFFFFF, 0, 1, 0, 1, 4'b0010), 0, 0, 3'd3, 32'h4);
    // R6 system descriptor
    send("R6 ldt load", mk_desc(32'h00901000, 20'h7, 0, 1, 0, 0, 4'b0010), 0, 0, 3'd0, 32'h0);
    // R7 data load privilege
    send("R7 dpl low", mk_desc(32'h5000, 20'hFF, 0, 1, 2, 1, 4'b0010), 3, 1, 3'd0, 32'h0);
    send("R7 dpl ok", mk_desc(32'h5000, 20'hFF, 0, 1, 3, 1, 4'b0010), 3, 1, 3'd0, 32'h0);
    send("R7 conforming", mk_desc(32'h6000, 20'hFF, 0, 1, 0, 1, 4'b1110), 3, 3, 3'd0, 32'h0);
    send("R7 code nonconf", mk_desc(32'h6000, 20'hFF, 0, 1, 0, 1, 4'b1010), 3, 3, 3'd0, 32'h0);
    // R8 stack load
    send("R8 stack ok", mk_desc(32'h7000, 20'hFF, 0, 1, 2, 1, 4'b0010), 2, 2, 3'd1, 32'h0);
    send("R8 stack rpl", mk_desc(32'h7000, 20'hFF, 0, 1, 2, 1, 4'b0010), 3, 2, 3'd1, 32'h0);
    send("R8 stack dpl", mk_desc(32'h7000, 20'hFF, 0, 1, 3, 1, 4'b0010), 2, 2, 3'd1, 32'h0);
    send("R8 stack code", mk_desc(32'h7000, 20'hFF, 0, 1, 2, 1, 4'b1010), 2, 2, 3'd1, 32'h0);
    // R9 priority: type beats limit, type beats privilege
    send("R9 type over limit", mk_desc(32'h0, 20'h1, 0, 1, 0, 1, 4'b1010), 0, 0, 3'd3, 32'h100);
    send("R9 type over priv", mk_desc(32'h0, 20'h1, 0, 1, 0, 1, 4'b1010), 3, 2, 3'd1, 32'h0);
    // R11 zero address on fault
    send("R11 zero lin", mk_desc(32'hDEAD0000, 20'h0, 0, 1, 0, 1, 4'b0010), 0, 0, 3'd2, 32'h1);

    // R10 back-pressure
    @(negedge clk);
    da = mk_desc(32'hAAAA0000, 20'hFFFFF, 0, 1, 0, 1, 4'b0010);
    db = mk_desc(32'hBBBB0000, 20'hFFFFF, 0, 1, 0, 1, 4'b0010);
    ea = model(da, 0, 0, 3'd2, 32'h1);
    eb = model(db, 0, 0, 3'd2, 32'h2);
    rsp_ready = 0;
    req_desc = da; req_selector = 0; req_cpl = 0; req_op = 3'd2; req_offset = 32'h1; req_valid = 1;
    @(negedge clk);
    req_desc = db; req_offset = 32'h2;
    chk("R10 stalled ready low", {34'h0, req_ready}, {34'h0, 1'b0});
    repeat (3) @(negedge clk);
    chk("R10 held response", {rsp_fault, rsp_linear}, ea);
    chk("R10 still valid", {34'h0, rsp_valid}, {34'h0, 1'b1});
    rsp_ready = 1;
    @(negedge clk);
    req_valid = 0;
    chk("R10 queued follows", {rsp_fault, rsp_linear}, eb);
    @(negedge clk);
    chk("R10 drained", {34'h0, rsp_valid}, {34'h0, 1'b0});

    // Random mix covering R1..R9
    for (int i = 0; i < 400; i++) begin
      logic [1:0] rp, c;
      logic [2:0] op;
      logic [31:0] off, lim;
      dr = {$urandom, $urandom};
      if ($urandom % 8 != 0) dr[47] = 1'b1;
      if ($urandom % 8 != 0) dr[44] = 1'b1;
      rp = 2'($urandom); c = 2'($urandom);
      op = 3'($urandom % 6);
      lim = dr[55] ? {dr[51:48], dr[15:0], 12'hFFF} : {12'h0, dr[51:48], dr[15:0]};
      off = ($urandom % 2 == 0) ? $urandom : lim + 32'($urandom % 3) - 32'd1;
      send("R9 random", dr, rp, c, op, off);
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule